// File: doc/BRIEF.md
# Frame Period Window Checker

This block checks that a vertical sync signal repeats with the right period. When started, it waits for one rising sync edge to line up with the frame. A guard timer bounds that wait. At the aligning edge it loads a down-counter with a fixed upper limit and decrements it on a tick that runs at two ticks per microsecond. At the next rising edge it takes the count, subtracts it from the load value and halves the difference to get the period in microseconds. It then judges that figure against an open tolerance window.

A run that passes on the reference clock is not finished at once. The block waits for a strobe saying that the pixel clock source has been switched. It then measures again up to a parameterised number of times and stops at the first pass. Every result comes out together with an attempt code, so software can tell which clock failed. The code is zero for the reference attempt. During the retries it counts down from the retry limit to one. An underflow of the period counter, or a missing first edge, ends the run at once without retries.

Top module: `frame_period_checker`

## Requirements
- R1: After reset, `done_o`, `pass_o`, `time_o` and `code_o` are all zero.
- R2: The sync input passes through two synchronising flops. Only a low-to-high transition counts as an edge, so a level held high gives a single event.
- R3: If no sync edge arrives within `ALIGN_TICKS` ticks of entering the alignment wait, the run ends with `pass_o`=0, `time_o` all ones and `code_o` equal to the current attempt code.
- R4: The tick phase restarts at the aligning edge, and the period counter loads `LOAD_TICKS` there. One tick falls every `TICK_DIV` cycles after that edge. Between two detected edges that are P cycles apart, the counter therefore loses floor((P-1)/`TICK_DIV`) ticks. The reported time is (`LOAD_TICKS` - count) / 2, rounded down.
- R5: A measurement passes only when the time is strictly greater than `LO_US` and strictly less than `HI_US`. Both bounds themselves fail.
- R6: If the period counter is at zero and another tick comes before the second edge, the run ends at once: `pass_o`=0, `time_o`=0, and no retry.
- R7: After a reference-clock pass, no result is issued. The block waits for `clk_chg_i`, then runs up to `RETRIES` attempts. Each attempt aligns on a new edge. The run ends at the first pass, or after attempt code 1. Attempt codes count down `RETRIES`, `RETRIES`-1, ..., 1, and the reference attempt uses code 0.
- R8: A reference attempt whose time is outside the window ends the run at once, with code 0 and the measured time.
- R9: `done_o` is high for exactly one cycle per run. `pass_o`, `time_o` and `code_o` change only at that cycle, or when they clear in the cycle after an accepted start. `start_i` is ignored while a run is in progress.
- R10: `clk_chg_i` has an effect only while the block is waiting for the clock switch. A strobe given earlier is not remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Vertical sync pulse, asynchronous |
| start_i | input | 1 | One-cycle start command |
| clk_chg_i | input | 1 | One-cycle strobe: pixel clock source has been switched |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Final verdict, held until the next start |
| time_o | output | TIME_W | Measured period in microseconds, 0 on underflow, all ones on missing sync |
| code_o | output | CODE_W | Attempt code of the final result |

## Verification
Most internal faults show up within one run as a wrong figure at `done_o`. A wrong tick phase or a counter that slips by one tick moves `time_o` by one microsecond. That turns a pass into a fail right at the window bounds, so those bounds are measured cycle-exactly. A wrong attempt counter or retry decision gives a wrong `code_o`, or a `done_o` that comes too early or too late. A bad edge detector gives a measurement where a held-high level should run into underflow. Guard and underflow faults show as a missing or early `done_o`, which appears thousands of cycles later.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_MEAS,
    ST_WAIT_SW
  } fpc_state_e;

  // Ticks consumed since the load, halved: two ticks per microsecond.
  function automatic logic [31:0] elapsed_us(input logic [31:0] load_val,
                                             input logic [31:0] remaining);
    return (load_val - remaining) >> 1;
  endfunction

  // Open tolerance window: both bounds are outside.
  function automatic logic in_window(input logic [31:0] us,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (us > lo) && (us < hi);
  endfunction

endpackage

// File: rtl/fpc_sync_edge.sv
module fpc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;

endmodule

// File: rtl/fpc_tick_gen.sv
module fpc_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_every_cycle
      assign tick_o = 1'b1;
    end else begin : g_divided
      localparam int PRE_W = $clog2(DIV);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pre_q <= '0;
        else if (restart_i)       pre_q <= '0;
        else if (pre_q == LAST)   pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
      end

      assign tick_o = (pre_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/fpc_down_timer.sv
module fpc_down_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         zero_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count_o <= '0;
    else if (load_i)                  count_o <= load_val_i;
    else if (dec_i && count_o != '0)  count_o <= count_o - 1'b1;
  end

  assign zero_o = (count_o == '0);

endmodule

// File: rtl/frame_period_checker.sv
module frame_period_checker #(
  parameter int TICK_DIV    = 50,
  parameter int LOAD_TICKS  = 64000,
  parameter int ALIGN_TICKS = 400000,
  parameter int LO_US       = 19800,
  parameter int HI_US       = 20200,
  parameter int RETRIES     = 5,
  parameter int TIME_W      = 20,
  parameter int CODE_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              start_i,
  input  logic              clk_chg_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [TIME_W-1:0] time_o,
  output logic [CODE_W-1:0] code_o
);
  import fpc_pkg::*;

  localparam int CNT_W = $clog2(LOAD_TICKS + 1);
  localparam int GRD_W = $clog2(ALIGN_TICKS + 1);
  localparam logic [CODE_W-1:0] RETRY_CODE = CODE_W'(RETRIES);

  fpc_state_e        st_q;
  logic [CODE_W-1:0] attempt_q;

  // Named internal events
  logic sync_edge_w, tick_w;
  logic start_acc_w, retry_go_w, again_w, to_wsw_w;
  logic meas_load_w, meas_edge_w, underflow_w, align_to_w;
  logic guard_reload_w, phase_rst_w, win_pass_w;
  logic finish_w, fin_pass_w;
  logic [TIME_W-1:0] fin_time_w;
  logic [31:0] us_w;

  logic [CNT_W-1:0] meas_cnt;
  logic             meas_zero;
  logic [GRD_W-1:0] guard_cnt;
  logic             guard_zero;

  fpc_sync_edge u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sync_i),
    .rise_o  (sync_edge_w)
  );

  fpc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (phase_rst_w),
    .tick_o    (tick_w)
  );

  fpc_down_timer #(.W(CNT_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (meas_load_w),
    .load_val_i (CNT_W'(LOAD_TICKS)),
    .dec_i      (st_q == ST_MEAS && tick_w),
    .count_o    (meas_cnt),
    .zero_o     (meas_zero)
  );

  fpc_down_timer #(.W(GRD_W)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (guard_reload_w),
    .load_val_i (GRD_W'(ALIGN_TICKS)),
    .dec_i      (st_q == ST_ALIGN && tick_w),
    .count_o    (guard_cnt),
    .zero_o     (guard_zero)
  );

  assign start_acc_w = (st_q == ST_IDLE) && start_i;
  assign retry_go_w  = (st_q == ST_WAIT_SW) && clk_chg_i;
  assign meas_load_w = (st_q == ST_ALIGN) && sync_edge_w;
  assign meas_edge_w = (st_q == ST_MEAS) && sync_edge_w;
  assign underflow_w = (st_q == ST_MEAS) && !sync_edge_w && tick_w && meas_zero;
  assign align_to_w  = (st_q == ST_ALIGN) && !sync_edge_w && tick_w && guard_zero;

  assign us_w       = elapsed_us(32'(LOAD_TICKS), 32'(meas_cnt));
  assign win_pass_w = in_window(us_w, 32'(LO_US), 32'(HI_US));

  always_comb begin
    finish_w   = 1'b0;
    fin_pass_w = 1'b0;
    fin_time_w = '0;
    to_wsw_w   = 1'b0;
    again_w    = 1'b0;
    if (align_to_w) begin
      finish_w   = 1'b1;
      fin_time_w = '1;
    end else if (underflow_w) begin
      finish_w   = 1'b1;
    end else if (meas_edge_w) begin
      if (attempt_q == '0 && win_pass_w && RETRIES > 0) begin
        to_wsw_w = 1'b1;
      end else if (attempt_q == '0 || win_pass_w || attempt_q == CODE_W'(1)) begin
        finish_w   = 1'b1;
        fin_pass_w = win_pass_w;
        fin_time_w = TIME_W'(us_w);
      end else begin
        again_w = 1'b1;
      end
    end
  end

  assign guard_reload_w = start_acc_w || retry_go_w || again_w;
  assign phase_rst_w    = guard_reload_w || meas_load_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      attempt_q <= '0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      time_o    <= '0;
      code_o    <= '0;
    end else begin
      done_o <= finish_w;
      if (finish_w) begin
        pass_o <= fin_pass_w;
        time_o <= fin_time_w;
        code_o <= attempt_q;
        st_q   <= ST_IDLE;
      end
      unique case (st_q)
        ST_IDLE: if (start_acc_w) begin
          st_q      <= ST_ALIGN;
          attempt_q <= '0;
          pass_o    <= 1'b0;
          time_o    <= '0;
          code_o    <= '0;
        end
        ST_ALIGN: if (meas_load_w) st_q <= ST_MEAS;
        ST_MEAS: begin
          if (to_wsw_w) begin
            st_q      <= ST_WAIT_SW;
            attempt_q <= RETRY_CODE;
          end else if (again_w) begin
            st_q      <= ST_ALIGN;
            attempt_q <= attempt_q - 1'b1;
          end
        end
        ST_WAIT_SW: if (retry_go_w) st_q <= ST_ALIGN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int LO_US   = 19800,
  parameter int HI_US   = 20200,
  parameter int RETRIES = 5,
  parameter int TIME_W  = 20,
  parameter int CODE_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_i,
  input logic              pass_i,
  input logic [TIME_W-1:0] time_i,
  input logic [CODE_W-1:0] code_i,
  input logic              edge_i,
  input logic              align_to_i,
  input logic              start_acc_i
);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i);

  a_r5_pass_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && pass_i) |-> (time_i > TIME_W'(LO_US) && time_i < TIME_W'(HI_US)));

  a_r6_zero_time_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && time_i == '0) |-> !pass_i);

  a_r7_code_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (code_i <= CODE_W'(RETRIES)));

  a_r2_edge_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !edge_i);

  a_r3_timeout_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    align_to_i |=> (done_i && !pass_i && time_i == '1));

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc_i |=> (done_i || ($stable(time_i) && $stable(pass_i) && $stable(code_i))));

endmodule

bind frame_period_checker fpc_checker #(
  .LO_US(LO_US), .HI_US(HI_US), .RETRIES(RETRIES), .TIME_W(TIME_W), .CODE_W(CODE_W)
) u_fpc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_i      (done_o),
  .pass_i      (pass_o),
  .time_i      (time_o),
  .code_i      (code_o),
  .edge_i      (sync_edge_w),
  .align_to_i  (align_to_w),
  .start_acc_i (start_acc_w)
);

// File: tb/frame_period_checker_tb_top.sv
module frame_period_checker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV   = 2;
  localparam int LOAD   = 640;
  localparam int ALIGN  = 2000;
  localparam int LO     = 198;
  localparam int HI     = 202;
  localparam int NRETRY = 3;
  localparam int TW     = 20;
  localparam int CW     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, start_i = 1'b0, clk_chg_i = 1'b0;
  logic done_o, pass_o;
  logic [TW-1:0] time_o;
  logic [CW-1:0] code_o;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int base_cnt = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_period_checker #(
    .TICK_DIV(TDIV), .LOAD_TICKS(LOAD), .ALIGN_TICKS(ALIGN), .LO_US(LO),
    .HI_US(HI), .RETRIES(NRETRY), .TIME_W(TW), .CODE_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .start_i(start_i),
    .clk_chg_i(clk_chg_i), .done_o(done_o), .pass_o(pass_o),
    .time_o(time_o), .code_o(code_o)
  );

  always @(posedge clk) if (done_o) done_cnt <= done_cnt + 1;

  // Expected microseconds for detected edges p cycles apart (R4)
  function automatic int exp_us(input int p);
    return ((p - 1) / TDIV) / 2;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    base_cnt = done_cnt;
  endtask

  task automatic do_chg();
    clk_chg_i = 1'b1; cyc(1); clk_chg_i = 1'b0;
  endtask

  task automatic pulse();
    sync_i = 1'b1; cyc(4); sync_i = 1'b0;
  endtask

  task automatic pair(input int p);
    pulse(); cyc(p - 4); pulse();
  endtask

  task automatic expect_result(input string req, input int ndone, input int ps,
                               input longint tm, input int cd);
    check({req, " done count"}, done_cnt - base_cnt, ndone);
    check({req, " pass"}, pass_o, ps);
    check({req, " time"}, time_o, tm);
    check({req, " code"}, code_o, cd);
  endtask

  task automatic t_reset();
    check("R1 done", done_o, 0);
    check("R1 pass", pass_o, 0);
    check("R1 time", time_o, 0);
    check("R1 code", code_o, 0);
  endtask

  task automatic t_ref_fail_low();   // R5 lower bound, R8
    do_start(); cyc(10); pair(796); cyc(10);
    expect_result("R8", 1, 0, exp_us(796), 0);
    check("R5 198 is outside", exp_us(796), 198);
  endtask

  task automatic t_ref_pass_retry(); // R7, R10, R5
    do_start(); do_chg(); cyc(10);
    pair(797); cyc(30);
    check("R7 no result after reference pass", done_cnt - base_cnt, 0);
    check("R9 outputs still cleared", time_o, 0);
    cyc(10); pair(801); cyc(30);
    check("R10 early strobe not remembered", done_cnt - base_cnt, 0);
    do_chg(); cyc(10); pair(801); cyc(10);
    expect_result("R7 first retry pass", 1, 1, 200, NRETRY);
  endtask

  task automatic t_upper_bound();    // R5
    do_start(); cyc(10); pair(809); cyc(10);
    expect_result("R5 upper bound fails", 1, 0, 202, 0);
    do_start(); cyc(10); pair(805); cyc(20); do_chg(); cyc(10); pair(805); cyc(10);
    expect_result("R5 just below upper bound", 1, 1, 201, NRETRY);
  endtask

  task automatic t_underflow();      // R6
    do_start(); cyc(10); pulse(); cyc(1500);
    expect_result("R6 underflow", 1, 0, 0, 0);
  endtask

  task automatic t_align_timeout();  // R3
    do_start(); cyc(3900);
    check("R3 no early timeout", done_cnt - base_cnt, 0);
    cyc(300);
    expect_result("R3 timeout", 1, 0, (1 << TW) - 1, 0);
  endtask

  task automatic t_held_high();      // R2
    do_start(); cyc(10); sync_i = 1'b1; cyc(1500);
    expect_result("R2 held level is one edge", 1, 0, 0, 0);
    sync_i = 1'b0; cyc(10);
  endtask

  task automatic t_retry_exhaust();  // R7
    do_start(); cyc(10); pair(801); cyc(20); do_chg();
    for (int k = 0; k < NRETRY; k++) begin
      cyc(20); pair(1000); cyc(20);
      if (k < NRETRY - 1)
        check("R7 no result between retries", done_cnt - base_cnt, 0);
    end
    expect_result("R7 retries exhausted", 1, 0, exp_us(1000), 1);
  endtask

  task automatic t_retry_then_pass(); // R7
    do_start(); cyc(10); pair(801); cyc(20); do_chg();
    cyc(20); pair(700); cyc(20);
    check("R7 failed retry continues", done_cnt - base_cnt, 0);
    pair(801); cyc(10);
    expect_result("R7 second retry pass", 1, 1, 200, NRETRY - 1);
  endtask

  task automatic t_start_ignored();  // R9
    do_start(); cyc(10);
    pulse(); cyc(296);
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    cyc(1000 - 4 - 296 - 1); pulse(); cyc(10);
    expect_result("R9 start ignored while busy", 1, 0, exp_us(1000), 0);
    cyc(50);
    expect_result("R9 result held", 1, 0, exp_us(1000), 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_ref_fail_low();
    t_ref_pass_retry();
    t_upper_bound();
    t_underflow();
    t_align_timeout();
    t_held_high();
    t_retry_exhaust();
    t_retry_then_pass();
    t_start_ignored();
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule